// File: doc/BRIEF.md
# Read/Write Dependency Ordering Gate

This block sits between a source of memory requests and the address channels of an AXI master port. The bus keeps order only between accesses of the same direction that carry the same ID. It gives no order at all between a read and a write, even when both use the same ID value. The gate supplies that missing order, but only where the source asks for it. Each request carries a dependency mark. A marked read waits until every write issued before it has received its write response. A marked write waits until every read issued before it has delivered its last data beat. Unmarked requests go straight through to the AR or AW channel in the cycle they are presented.

Requests enter through one valid/ready queue. They leave in the order they arrive, so a held request also holds every request behind it. The gate keeps two small counters of outstanding work. One counts reads that have been issued but have not yet returned their final beat. The other counts writes that have been issued but have not yet returned a response. The gate watches the B and R response handshakes but does not drive them. To order two accesses of the same direction, the source gives them the same ID. The gate adds no wait in that case.

Top module: `dep_order_gate`

## Requirements
- R1: An unmarked read (`req_write`=0, `req_dep`=0) drives `ar_valid` equal to `req_valid` in the same cycle, and `req_ready` equals `ar_ready`, whatever writes are outstanding, provided fewer than 15 reads are outstanding.
- R2: An unmarked write (`req_write`=1, `req_dep`=0) drives `aw_valid` equal to `req_valid` in the same cycle, and `req_ready` equals `aw_ready`, whatever reads are outstanding, provided fewer than 15 writes are outstanding.
- R3: A marked read (`req_dep`=1) keeps `ar_valid` and `req_ready` low while any earlier write has not yet had its B handshake.
- R4: A marked write keeps `aw_valid` and `req_ready` low while any earlier read has not yet had its final R handshake. An R handshake with `r_last`=0 does not complete a read.
- R5: The read count rises by one on each AR handshake. It falls by one on each R handshake with `r_last`=1. The write count rises on each AW handshake and falls on each B handshake. A rise and a fall in the same cycle leave the count unchanged. A held request is released in the cycle after the handshake that brings the opposite count to zero.
- R6: When 15 accesses of one direction are outstanding, a request of that direction is held (`req_ready` and the channel valid are low) until one of them completes.
- R7: `ar_valid` and `aw_valid` are never high together. `ar_id`/`aw_id` carry `req_id` unchanged.
- R8: `req_ready` is high only when the request is accepted on its channel in that cycle. Once `ar_valid` or `aw_valid` is raised without a ready, it stays high until the handshake.
- R9: After reset both counts are zero, so a marked request issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_dep | input | 1 | Request depends on earlier opposite-direction traffic |
| req_id | input | ID_W | Transaction ID |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | output | ID_W | Read ID |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | output | ID_W | Write ID |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_last | input | 1 | Final read beat marker (observed) |

## Verification
The assertions assume the response side never completes more transactions than are outstanding. No B handshake comes while the write count is zero, and no R beat comes while the read count is zero. They also assume the source keeps a request, its direction, mark and ID, stable until it is accepted. The stimulus meets both assumptions. It generates responses only while its own model shows outstanding work of that direction. It also holds each request until the model shows it accepted. This holds for the directed cases, including the full-counter and final-beat cases, and for the random phase with its shifting response rates.

// File: rtl/dep_order_gate_pkg.sv
package dep_order_gate_pkg;

  // Direction of a request; the value also indexes the counter array.
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  localparam int NUM_DIRS = 2;

  function automatic dir_e opposite(input dir_e d);
    return (d == DIR_RD) ? DIR_WR : DIR_RD;
  endfunction

endpackage

// File: rtl/dgate_outstanding_ctr.sv
module dgate_outstanding_ctr #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic empty_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Next-state logic: the count changes only when exactly one side fires.
  always_comb begin
    cnt_en = inc_i ^ dec_i;
    cnt_d  = cnt_q;
    if (inc_i && !dec_i) begin
      cnt_d = cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);

  // R6: the issuing side must never push a full counter.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !inc_i);

  // R5: input assumption, no completion without outstanding work.
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !dec_i);

  // R5: a lone issue raises the count by one.
  assert_inc_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R5: simultaneous issue and completion leave the count unchanged.
  assert_balanced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dgate_release_ctrl.sv
module dgate_release_ctrl
  import dep_order_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  dir_e req_dir,
  input  logic req_dep,
  input  logic rd_full,
  input  logic wr_full,
  input  logic rd_empty,
  input  logic wr_empty,
  input  logic ar_ready,
  input  logic aw_ready,
  output logic ar_valid,
  output logic aw_valid,
  output logic req_ready
);

  logic rd_go;
  logic wr_go;

  // A direction may issue when its own counter has room and, for a
  // marked request, the opposite direction has fully drained.
  always_comb begin
    rd_go     = !rd_full && !(req_dep && !wr_empty);
    wr_go     = !wr_full && !(req_dep && !rd_empty);
    ar_valid  = req_valid && (req_dir == DIR_RD) && rd_go;
    aw_valid  = req_valid && (req_dir == DIR_WR) && wr_go;
    req_ready = (req_dir == DIR_RD) ? (rd_go && ar_ready) : (wr_go && aw_ready);
  end

  // R3: a marked read reaches AR only with no write outstanding.
  assert_dep_read_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && req_dep) |-> wr_empty);

  // R4: a marked write reaches AW only with no read outstanding.
  assert_dep_write_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && req_dep) |-> rd_empty);

  // R7: one queue, one channel at a time.
  assert_one_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ar_valid && aw_valid));

  // R8: a raised valid is not withdrawn before its handshake
  // (relies on the source holding its request).
  assert_ar_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> ar_valid);
  assert_aw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> aw_valid);

endmodule

// File: rtl/dep_order_gate.sv
module dep_order_gate
  import dep_order_gate_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_dep,
  input  logic [ID_W-1:0] req_id,
  output logic            ar_valid,
  input  logic            ar_ready,
  output logic [ID_W-1:0] ar_id,
  output logic            aw_valid,
  input  logic            aw_ready,
  output logic [ID_W-1:0] aw_id,
  input  logic            b_valid,
  input  logic            b_ready,
  input  logic            r_valid,
  input  logic            r_ready,
  input  logic            r_last
);

  dir_e                req_dir;
  logic [NUM_DIRS-1:0] ctr_inc;
  logic [NUM_DIRS-1:0] ctr_dec;
  logic [NUM_DIRS-1:0] ctr_full;
  logic [NUM_DIRS-1:0] ctr_empty;

  assign req_dir = req_write ? DIR_WR : DIR_RD;
  assign ar_id   = req_id;
  assign aw_id   = req_id;

  // Issue and completion events per direction.
  always_comb begin
    ctr_inc[DIR_RD] = ar_valid && ar_ready;
    ctr_inc[DIR_WR] = aw_valid && aw_ready;
    ctr_dec[DIR_RD] = r_valid && r_ready && r_last;
    ctr_dec[DIR_WR] = b_valid && b_ready;
  end

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_ctr
    dgate_outstanding_ctr #(
      .CNT_W (CNT_W)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (ctr_inc[d]),
      .dec_i   (ctr_dec[d]),
      .full_o  (ctr_full[d]),
      .empty_o (ctr_empty[d])
    );
  end

  dgate_release_ctrl u_release (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_dir   (req_dir),
    .req_dep   (req_dep),
    .rd_full   (ctr_full[DIR_RD]),
    .wr_full   (ctr_full[DIR_WR]),
    .rd_empty  (ctr_empty[DIR_RD]),
    .wr_empty  (ctr_empty[DIR_WR]),
    .ar_ready  (ar_ready),
    .aw_ready  (aw_ready),
    .ar_valid  (ar_valid),
    .aw_valid  (aw_valid),
    .req_ready (req_ready)
  );

  // R8: an accepted request always corresponds to a channel handshake.
  assert_accept_is_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ((ar_valid && ar_ready) || (aw_valid && aw_ready)));

  // R1: an unmarked read is never held while its counter has room.
  assert_free_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_dep && !ctr_full[DIR_RD]) |-> ar_valid);

  // R2: an unmarked write is never held while its counter has room.
  assert_free_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_dep && !ctr_full[DIR_WR]) |-> aw_valid);

endmodule

// File: tb/dep_order_gate_test.sv
module dep_order_gate_test;

  localparam int ID_W  = 4;
  localparam int CNT_W = 4;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic            req_dep = 1'b0;
  logic [ID_W-1:0] req_id = '0;
  logic            ar_valid;
  logic            ar_ready = 1'b0;
  logic [ID_W-1:0] ar_id;
  logic            aw_valid;
  logic            aw_ready = 1'b0;
  logic [ID_W-1:0] aw_id;
  logic            b_valid = 1'b0;
  logic            b_ready = 1'b0;
  logic            r_valid = 1'b0;
  logic            r_ready = 1'b0;
  logic            r_last = 1'b0;

  int checks = 0;
  int fails  = 0;
  int rd_out = 0;
  int wr_out = 0;
  logic accepted;

  always #2 clk = ~clk;

  dep_order_gate #(.ID_W(ID_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dep(req_dep), .req_id(req_id),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .b_valid(b_valid), .b_ready(b_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (rd_out=%0d wr_out=%0d)",
               tag, what, act, exp, rd_out, wr_out);
    end
  endtask

  // One clock of stimulus, compared with the behavioural model.
  task automatic step(input logic pv, input logic pw, input logic pd,
                      input logic [ID_W-1:0] pid, input logic arr, input logic awr,
                      input logic bf, input logic rf, input logic rl, input string note);
    logic rd_go, wr_go, exp_ar, exp_aw, exp_rdy;
    string tag_r, tag_w;
    @(negedge clk);
    req_valid = pv; req_write = pw; req_dep = pd; req_id = pid;
    ar_ready = arr; aw_ready = awr;
    b_valid = bf; b_ready = bf;
    r_valid = rf; r_ready = rf; r_last = rl;
    #1;
    rd_go   = (rd_out < MAXC) && !(pd && wr_out != 0);
    wr_go   = (wr_out < MAXC) && !(pd && rd_out != 0);
    exp_ar  = pv && !pw && rd_go;
    exp_aw  = pv && pw && wr_go;
    exp_rdy = pw ? (wr_go && awr) : (rd_go && arr);
    tag_r = (note != "") ? note : (pd ? "R3" : ((rd_out == MAXC) ? "R6" : "R1"));
    tag_w = (note != "") ? note : (pd ? "R4" : ((wr_out == MAXC) ? "R6" : "R2"));
    check(tag_r, "ar_valid", int'(ar_valid), int'(exp_ar));
    check(tag_w, "aw_valid", int'(aw_valid), int'(exp_aw));
    check("R7", "one channel", int'(ar_valid && aw_valid), 0);
    if (pv) begin
      check(pw ? tag_w : tag_r, "req_ready R8", int'(req_ready), int'(exp_rdy));
      if (exp_ar) check("R7", "ar_id", int'(ar_id), int'(pid));
      if (exp_aw) check("R7", "aw_id", int'(aw_id), int'(pid));
    end
    accepted = pv && exp_rdy;
    @(posedge clk);
    // R5: model counters
    if (exp_ar && arr) rd_out++;
    if (exp_aw && awr) wr_out++;
    if (rf && rl) rd_out--;
    if (bf) wr_out--;
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic pv, pw, pd;
    logic [ID_W-1:0] pid;
    // Reset state: nothing presented, no channel valid.
    repeat (3) @(posedge clk);
    #1;
    check("R9", "ar_valid in reset", int'(ar_valid), 0);
    check("R9", "aw_valid in reset", int'(aw_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: marked read issues at once after reset.
    step(1, 0, 1, 4'h3, 1, 0, 0, 0, 0, "R9");
    // R4: marked write held while the read is open; non-last beat does not help.
    step(1, 1, 1, 4'h5, 0, 1, 0, 0, 0, "R4");
    step(1, 1, 1, 4'h5, 0, 1, 0, 1, 0, "R4");
    step(1, 1, 1, 4'h5, 0, 1, 0, 1, 1, "R4");
    // R5: released the cycle after the final beat.
    step(1, 1, 1, 4'h5, 0, 1, 0, 0, 0, "R5");
    // R1: unmarked read passes although a write is open.
    step(1, 0, 0, 4'h5, 1, 0, 0, 0, 0, "R1");
    // R3: marked read waits for the B handshake.
    step(1, 0, 1, 4'h9, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 4'h9, 1, 0, 1, 0, 0, "R3");
    // R8: allowed but AR not ready: valid up, ready low, valid held.
    step(1, 0, 1, 4'h9, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 1, 4'h9, 1, 0, 0, 0, 0, "R8");
    // R2: unmarked write passes with reads open.
    step(1, 1, 0, 4'h1, 0, 1, 0, 0, 0, "R2");
    // R6: fill the write counter, then a further write is held.
    while (wr_out < MAXC) step(1, 1, 0, 4'h2, 0, 1, 0, 0, 0, "R6");
    step(1, 1, 0, 4'h2, 0, 1, 0, 0, 0, "R6");
    step(1, 1, 0, 4'h2, 0, 1, 1, 0, 0, "R6");
    step(1, 1, 0, 4'h2, 0, 1, 0, 0, 0, "R6");
    // R5: issue and completion in the same cycle.
    step(1, 0, 0, 4'h7, 1, 0, 0, 1, 1, "R5");

    // Random phase with shifting response rates.
    pv = 0; pw = 0; pd = 0; pid = '0;
    for (int i = 0; i < 6000; i++) begin
      int rate;
      logic bf, rf, rl;
      rate = ((i / 500) % 3 == 0) ? 2 : (((i / 500) % 3 == 1) ? 30 : 70);
      if (!pv && ($urandom % 100) < 80) begin
        pv = 1; pw = $urandom % 2; pd = (($urandom % 100) < 35); pid = ID_W'($urandom);
      end
      bf = (wr_out > 0) && (($urandom % 100) < rate);
      rf = (rd_out > 0) && (($urandom % 100) < rate);
      rl = rf && (($urandom % 3) != 0);
      step(pv, pw, pd, pid, ($urandom % 4) != 0, ($urandom % 4) != 0, bf, rf, rl, "");
      if (accepted) pv = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule